// File: doc/BRIEF.md
# SIMT Warp Divergence Mask Stack

This block keeps the active-lane mask of a single 32-lane SIMT warp while the warp runs through conditional branches, nested branches and loops. The lanes share one instruction decoder, so the warp follows one control path at a time. Lanes outside the active mask still spend the issue slot. Their results are thrown away because each lane's write enable equals its mask bit.

On a branch event the block receives a per-lane predicate, the taken target, the address of the next sequential instruction and the merge (reconvergence) address. When the active lanes agree, the warp redirects without storing anything. When they disagree, the block stores the not-taken half together with the mask in force before the branch, and runs the taken half first. At each merge event the block either starts the stored half or, once both halves are done, restores the earlier mask so that the code after the merge runs once at full width. A half that no lane takes is never issued. A loop back-edge that reuses the current stack entry adds the lanes that exit to that entry, and those lanes stay masked until the last lane leaves the loop.

Top module: `simt_reconv_stack`

## Requirements
- R1: Synchronous active-high reset sets `next_pc` to 0, `active_mask` to all ones (bit i = lane i, 1 = active), clears both error flags and empties the stack.
- R2: `next_pc` and `active_mask` are registered: they change on the clock edge that samples an event and hold their values in cycles with neither `is_branch` nor `is_reconv`.
- R3: On a branch where `pred & active_mask` equals `active_mask`, the next PC is `target_pc`. Where it is zero, the next PC is `seq_pc`. In both cases the mask is unchanged and nothing is pushed.
- R4: On a branch where the active lanes disagree, an entry {merge PC = `reconv_pc`, pending PC = `seq_pc`, pending mask = `~pred & active_mask`, saved mask = `active_mask`} is pushed, the next PC is `target_pc` and the mask becomes `pred & active_mask`.
- R5: On a merge event, if the top entry has a non-empty pending mask and its pending PC differs from its merge PC, the next PC becomes the pending PC and the mask becomes the pending mask. The pending mask in the entry is then cleared.
- R6: On a merge event in any other case, the top entry is popped, the next PC becomes its merge PC and the mask becomes its saved mask.
- R7: The active mask is never all zeros: a path with an empty lane mask is never issued.
- R8: A disagreeing branch whose `reconv_pc` and `seq_pc` equal the top entry's merge PC and pending PC is treated as a loop back-edge. Nothing is pushed, the exiting lanes are ORed into that entry's pending mask, and the warp runs the loop body under `pred & active_mask`. When the last active lanes exit, one merge event restores the full mask.
- R9: A merge event on an empty stack sets the sticky `underflow` flag and leaves `next_pc` and `active_mask` unchanged.
- R10: A disagreeing branch that needs a push while the stack holds DEPTH (8) entries sets the sticky `overflow` flag. The branch is dropped, and the stack, `next_pc` and `active_mask` are unchanged.
- R11: When `is_branch` and `is_reconv` are both high in one cycle, only the branch is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_branch | input | 1 | Branch event this cycle |
| is_reconv | input | 1 | Merge-point event this cycle |
| pred | input | 32 | Per-lane branch predicate, 1 = lane takes the branch |
| target_pc | input | 16 | Taken-path address |
| seq_pc | input | 16 | Fall-through (next sequential) address |
| reconv_pc | input | 16 | Merge address for this branch |
| next_pc | output | 16 | Registered address to fetch next |
| active_mask | output | 32 | Registered lane mask, also the per-lane write enable |
| overflow | output | 1 | Sticky: push attempted on a full stack |
| underflow | output | 1 | Sticky: merge event on an empty stack |

## Verification
A corrupted stack entry shows up at the first merge event that reaches it. That event yields a wrong `next_pc` or `active_mask`, one cycle after it is sampled. A wrong stack depth can stay hidden until an unwind or a fill reaches the bottom or the top. The error then appears as an early or missing underflow or overflow, or as a restored mask that belongs to a different nesting level. The bench therefore nests branches, runs a loop whose lanes exit at different iterations and fills the stack to exactly DEPTH entries. It then unwinds every level one event at a time, so a depth error cannot pass unnoticed.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
    localparam int LANES = 32;
    localparam int PC_W  = 16;

    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [PC_W-1:0]  pc_t;

    // One level of divergence bookkeeping
    typedef struct packed {
        pc_t        merge_pc;   // where both halves meet again
        pc_t        pend_pc;    // start of the half not yet run
        lane_mask_t pend_mask;  // lanes waiting for that half
        lane_mask_t saved_mask; // mask in force before the branch
    } stk_entry_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_UNIFORM,
        ACT_PUSH,
        ACT_MERGE,
        ACT_OVF,
        ACT_SWITCH,
        ACT_POP,
        ACT_UDF
    } stk_act_e;

    // A back-edge reuses the top entry when it targets the same exit
    function automatic logic same_region(input stk_entry_t e, input pc_t rpc, input pc_t spc);
        return (e.merge_pc == rpc) && (e.pend_pc == spc);
    endfunction

    // The stored half is worth issuing only if it has lanes and is not the merge point
    function automatic logic pending_runnable(input stk_entry_t e);
        return (e.pend_mask != '0) && (e.pend_pc != e.merge_pc);
    endfunction
endpackage

// File: rtl/simt_stack_store.sv
module simt_stack_store
    import simt_div_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             top_we,
    input  stk_entry_t       push_data,
    input  stk_entry_t       top_data,
    output stk_entry_t       top,
    output logic [CNT_W-1:0] depth,
    output logic             empty,
    output logic             full
);
    stk_entry_t       mem [DEPTH];
    logic [CNT_W-1:0] top_cnt;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign top_cnt = depth - CNT_W'(1);
    assign top_idx = top_cnt[IDX_W-1:0];
    assign wr_idx  = depth[IDX_W-1:0];
    assign empty   = (depth == '0);
    assign full    = (depth == CNT_W'(DEPTH));
    assign top     = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else if (push && !full) begin
            mem[wr_idx] <= push_data;
            depth       <= depth + CNT_W'(1);
        end else if (pop && !empty) begin
            depth <= depth - CNT_W'(1);
        end else if (top_we && !empty) begin
            mem[top_idx] <= top_data;
        end
    end
endmodule

// File: rtl/simt_branch_decide.sv
module simt_branch_decide
    import simt_div_pkg::*;
(
    input  logic       is_branch,
    input  logic       is_reconv,
    input  lane_mask_t pred,
    input  pc_t        target_pc,
    input  pc_t        seq_pc,
    input  pc_t        reconv_pc,
    input  pc_t        cur_pc,
    input  lane_mask_t cur_mask,
    input  stk_entry_t top,
    input  logic       empty,
    input  logic       full,
    output stk_act_e   act,
    output pc_t        nxt_pc,
    output lane_mask_t nxt_mask,
    output stk_entry_t push_entry,
    output stk_entry_t top_new
);
    lane_mask_t taken_m;
    lane_mask_t fall_m;
    logic       loop_hit;

    assign taken_m  = pred & cur_mask;
    assign fall_m   = ~pred & cur_mask;
    assign loop_hit = !empty && same_region(top, reconv_pc, seq_pc);

    always_comb begin
        act        = ACT_HOLD;
        nxt_pc     = cur_pc;
        nxt_mask   = cur_mask;
        push_entry = '{merge_pc: reconv_pc, pend_pc: seq_pc,
                       pend_mask: fall_m, saved_mask: cur_mask};
        top_new    = top;
        if (is_branch) begin
            if (taken_m == '0) begin
                act    = ACT_UNIFORM;
                nxt_pc = seq_pc;
            end else if (fall_m == '0) begin
                act    = ACT_UNIFORM;
                nxt_pc = target_pc;
            end else if (loop_hit) begin
                act               = ACT_MERGE;
                top_new.pend_mask = top.pend_mask | fall_m;
                nxt_pc            = target_pc;
                nxt_mask          = taken_m;
            end else if (full) begin
                act = ACT_OVF;
            end else begin
                act      = ACT_PUSH;
                nxt_pc   = target_pc;
                nxt_mask = taken_m;
            end
        end else if (is_reconv) begin
            if (empty) begin
                act = ACT_UDF;
            end else if (pending_runnable(top)) begin
                act               = ACT_SWITCH;
                nxt_pc            = top.pend_pc;
                nxt_mask          = top.pend_mask;
                top_new.pend_mask = '0;
            end else begin
                act      = ACT_POP;
                nxt_pc   = top.merge_pc;
                nxt_mask = top.saved_mask;
            end
        end
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_div_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             is_branch,
    input  logic             is_reconv,
    input  logic [LANES-1:0] pred,
    input  logic [PC_W-1:0]  target_pc,
    input  logic [PC_W-1:0]  seq_pc,
    input  logic [PC_W-1:0]  reconv_pc,
    output logic [PC_W-1:0]  next_pc,
    output logic [LANES-1:0] active_mask,
    output logic             overflow,
    output logic             underflow
);
    stk_act_e         act;
    pc_t              nxt_pc;
    lane_mask_t       nxt_mask;
    stk_entry_t       push_entry;
    stk_entry_t       top_new;
    stk_entry_t       top;
    logic [CNT_W-1:0] depth;
    logic             empty;
    logic             full;

    simt_branch_decide u_decide (
        .is_branch  (is_branch),
        .is_reconv  (is_reconv),
        .pred       (pred),
        .target_pc  (target_pc),
        .seq_pc     (seq_pc),
        .reconv_pc  (reconv_pc),
        .cur_pc     (next_pc),
        .cur_mask   (active_mask),
        .top        (top),
        .empty      (empty),
        .full       (full),
        .act        (act),
        .nxt_pc     (nxt_pc),
        .nxt_mask   (nxt_mask),
        .push_entry (push_entry),
        .top_new    (top_new)
    );

    simt_stack_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (act == ACT_PUSH),
        .pop       (act == ACT_POP),
        .top_we    ((act == ACT_MERGE) || (act == ACT_SWITCH)),
        .push_data (push_entry),
        .top_data  (top_new),
        .top       (top),
        .depth     (depth),
        .empty     (empty),
        .full      (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc     <= '0;
            active_mask <= '1;
            overflow    <= 1'b0;
            underflow   <= 1'b0;
        end else begin
            next_pc     <= nxt_pc;
            active_mask <= nxt_mask;
            if (act == ACT_OVF) overflow  <= 1'b1;
            if (act == ACT_UDF) underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/simt_div_checker.sv
module simt_div_checker
    import simt_div_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             is_branch,
    input logic             is_reconv,
    input logic [LANES-1:0] pred,
    input logic [PC_W-1:0]  target_pc,
    input logic [PC_W-1:0]  seq_pc,
    input logic [PC_W-1:0]  next_pc,
    input logic [LANES-1:0] active_mask,
    input logic             overflow,
    input logic             underflow,
    input logic [CNT_W-1:0] depth
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (active_mask == '1) && (next_pc == '0) && !overflow && !underflow);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!is_branch && !is_reconv) |=> $stable(active_mask) && $stable(next_pc));

    assert_uniform_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (is_branch && ((pred & active_mask) == active_mask))
        |=> $stable(active_mask) && (next_pc == $past(target_pc)) && $stable(depth));

    assert_uniform_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (is_branch && ((pred & active_mask) == '0))
        |=> $stable(active_mask) && (next_pc == $past(seq_pc)) && $stable(depth));

    assert_branch_narrows_R4: assert property (@(posedge clk) disable iff (rst)
        is_branch |=> ((active_mask & ~$past(active_mask)) == '0));

    assert_mask_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
        active_mask != '0);

    assert_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        (is_reconv && !is_branch && (depth == '0))
        |=> underflow && $stable(active_mask) && $stable(next_pc));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (depth == CNT_W'(DEPTH)) |=> (depth <= CNT_W'(DEPTH)));

    assert_sticky_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (overflow || underflow) |=> ($past(overflow) -> overflow) && ($past(underflow) -> underflow));

    assert_branch_first_R11: assert property (@(posedge clk) disable iff (rst)
        (is_branch && is_reconv && (depth == '0)) |=> (underflow == $past(underflow)));
endmodule

bind simt_reconv_stack simt_div_checker #(.DEPTH(DEPTH)) u_div_chk (
    .clk         (clk),
    .rst         (rst),
    .is_branch   (is_branch),
    .is_reconv   (is_reconv),
    .pred        (pred),
    .target_pc   (target_pc),
    .seq_pc      (seq_pc),
    .next_pc     (next_pc),
    .active_mask (active_mask),
    .overflow    (overflow),
    .underflow   (underflow),
    .depth       (depth)
);

// File: tb/tb_simt_reconv_stack.sv
`timescale 1ns/1ps
module tb_simt_reconv_stack;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        is_branch = 1'b0;
    logic        is_reconv = 1'b0;
    logic [31:0] pred = '0;
    logic [15:0] target_pc = '0;
    logic [15:0] seq_pc = '0;
    logic [15:0] reconv_pc = '0;
    logic [15:0] next_pc;
    logic [31:0] active_mask;
    logic        overflow;
    logic        underflow;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [15:0] q_pc[$];
    logic [31:0] q_mask[$];
    logic        q_ovf[$];
    logic        q_udf[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    simt_reconv_stack dut (
        .clk(clk), .rst(rst), .is_branch(is_branch), .is_reconv(is_reconv),
        .pred(pred), .target_pc(target_pc), .seq_pc(seq_pc), .reconv_pc(reconv_pc),
        .next_pc(next_pc), .active_mask(active_mask),
        .overflow(overflow), .underflow(underflow)
    );

    // driver: one event per call, expectation queued for the edge that samples it
    task automatic step(input logic br, input logic rc, input logic [31:0] p,
                        input logic [15:0] tg, input logic [15:0] rp, input logic [15:0] sp,
                        input logic [15:0] epc, input logic [31:0] em,
                        input logic eo, input logic eu, input string tag);
        @(negedge clk);
        is_branch = br; is_reconv = rc; pred = p;
        target_pc = tg; reconv_pc = rp; seq_pc = sp;
        q_pc.push_back(epc); q_mask.push_back(em);
        q_ovf.push_back(eo); q_udf.push_back(eu); q_tag.push_back(tag);
        @(posedge clk);
        #1;
        is_branch = 1'b0; is_reconv = 1'b0;
    endtask

    task automatic br_ev(input logic [31:0] p, input logic [15:0] tg, input logic [15:0] rp,
                         input logic [15:0] sp, input logic [15:0] epc, input logic [31:0] em,
                         input logic eo, input logic eu, input string tag);
        step(1'b1, 1'b0, p, tg, rp, sp, epc, em, eo, eu, tag);
    endtask

    task automatic rc_ev(input logic [15:0] epc, input logic [31:0] em,
                         input logic eo, input logic eu, input string tag);
        step(1'b0, 1'b1, '0, '0, '0, '0, epc, em, eo, eu, tag);
    endtask

    // monitor: compares after the registered outputs have settled
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_pc.size() > 0) begin
                logic [15:0] epc;
                logic [31:0] em;
                logic        eo;
                logic        eu;
                string       tg;
                epc = q_pc.pop_front(); em = q_mask.pop_front();
                eo = q_ovf.pop_front(); eu = q_udf.pop_front(); tg = q_tag.pop_front();
                vectors++;
                if (next_pc !== epc || active_mask !== em || overflow !== eo || underflow !== eu) begin
                    miscompares++;
                    $display("FAIL %s: got pc=%h mask=%h ovf=%b udf=%b, expected pc=%h mask=%h ovf=%b udf=%b",
                             tg, next_pc, active_mask, overflow, underflow, epc, em, eo, eu);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 hold with no event
        step(1'b0, 1'b0, '0, '0, '0, '0, 16'h0000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1 reset/R2 hold");
        // R11 branch wins over merge event on an empty stack: no underflow
        step(1'b1, 1'b1, 32'hFFFF_FFFF, 16'h0010, 16'h0020, 16'h0001,
             16'h0010, 32'hFFFF_FFFF, 1'b0, 1'b0, "R11 branch priority");
        // R3 uniform not-taken
        br_ev(32'h0, 16'h0099, 16'h0020, 16'h0011, 16'h0011, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3 uniform fall");
        // R4 divergence, R5 pending half, R6 pop
        br_ev(32'h0000_FFFF, 16'h0030, 16'h0040, 16'h0012, 16'h0030, 32'h0000_FFFF, 1'b0, 1'b0, "R4 diverge");
        step(1'b0, 1'b0, '0, '0, '0, '0, 16'h0030, 32'h0000_FFFF, 1'b0, 1'b0, "R2 idle hold");
        rc_ev(16'h0012, 32'hFFFF_0000, 1'b0, 1'b0, "R5 run pending half");
        rc_ev(16'h0040, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 pop restores");
        // R9 underflow on empty stack
        rc_ev(16'h0040, 32'hFFFF_FFFF, 1'b0, 1'b1, "R9 underflow");
        // nesting, R7 empty half never issued
        br_ev(32'h0000_00FF, 16'h0050, 16'h0090, 16'h0041, 16'h0050, 32'h0000_00FF, 1'b0, 1'b1, "R4 outer");
        br_ev(32'h0000_000F, 16'h0060, 16'h0070, 16'h0051, 16'h0060, 32'h0000_000F, 1'b0, 1'b1, "R4 inner");
        br_ev(32'hFFFF_FFFF, 16'h0065, 16'h0068, 16'h0061, 16'h0065, 32'h0000_000F, 1'b0, 1'b1, "R7 skip empty half");
        rc_ev(16'h0051, 32'h0000_00F0, 1'b0, 1'b1, "R5 inner pending");
        rc_ev(16'h0070, 32'h0000_00FF, 1'b0, 1'b1, "R6 inner pop");
        rc_ev(16'h0041, 32'hFFFF_FF00, 1'b0, 1'b1, "R5 outer pending");
        rc_ev(16'h0090, 32'hFFFF_FFFF, 1'b0, 1'b1, "R6 outer pop");
        // R8 loop: lanes exit at different iterations
        br_ev(32'hFFFF_FFF0, 16'h00A0, 16'h00B0, 16'h00B0, 16'h00A0, 32'hFFFF_FFF0, 1'b0, 1'b1, "R8 loop iter1");
        br_ev(32'h0000_FFF0, 16'h00A0, 16'h00B0, 16'h00B0, 16'h00A0, 32'h0000_FFF0, 1'b0, 1'b1, "R8 loop iter2");
        br_ev(32'h0000_0000, 16'h00A0, 16'h00B0, 16'h00B0, 16'h00B0, 32'h0000_FFF0, 1'b0, 1'b1, "R8 exited lanes held");
        rc_ev(16'h00B0, 32'hFFFF_FFFF, 1'b0, 1'b1, "R8 loop merge restore");
        // R10: fill exactly DEPTH levels (loop above must have used one entry only)
        for (int i = 0; i < 8; i++) begin
            br_ev(~(32'h1 << i), 16'(16'h0100 + i), 16'(16'h0200 + i), 16'(16'h0180 + i),
                  16'(16'h0100 + i), ~((32'h2 << i) - 32'h1), 1'b0, 1'b1, "R4 fill level");
        end
        br_ev(~(32'h1 << 8), 16'h0108, 16'h0208, 16'h0188,
              16'h0107, 32'hFFFF_FF00, 1'b1, 1'b1, "R10 overflow drop");
        for (int i = 7; i >= 0; i--) begin
            rc_ev(16'(16'h0180 + i), 32'h1 << i, 1'b1, 1'b1, "R5 unwind pending");
            rc_ev(16'(16'h0200 + i), ~((32'h1 << i) - 32'h1), 1'b1, 1'b1, "R6 unwind pop");
        end
        rc_ev(16'h0200, 32'hFFFF_FFFF, 1'b1, 1'b1, "R9 empty after unwind");

        repeat (3) @(posedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule